// File: doc/BRIEF.md
# Four-Bit Indirect Register Microprocessor Port

This block is the host-side control port of a four-channel line power controller. A processor reaches it over a small asynchronous bus: a 4-bit data bus, one address bit, an address latch strobe, a chip select and active-low read and write strobes. The address bit picks one of two locations. At address 0 sits a selection register: a 3-bit code that names a group of per-channel status bits, plus an interrupt enable. At address 1 sits the line request register, one bit per channel, where 1 asks for turn-on and 0 asks for turn-off.

A read at address 1 returns the four channel bits of the group named by the selection code. A read at address 0 returns the code itself, with the over-temperature flag in the top bit instead of the interrupt enable. The line request bits reach the driver control register only for channels whose request the thermal and sequencing logic accepts. An active-low interrupt output follows the overload bits whenever the enable is set. All bus pins pass through a two-stage synchronizer into the block clock. The read data and its output enable are registered, so they follow the pins after three clocks.

Top module: `upport4`

## Requirements
- R1: After reset the interrupt output is high, the request and drive registers are 0000, the selection code is 000 with the interrupt enable clear, and the data output enable is low.
- R2: The data output enable is high only while chip select and read strobe are both low, and it trails the pins by three clocks. With chip select high it stays low even if the read strobe is low.
- R3: The address latch follows the address pin while the latch strobe is high. It holds the value present when the strobe falls.
- R4: A write takes effect when the write strobe or chip select rises, whichever rises first. At address 0 it stores data bits 2..0 as the selection code and data bit 3 as the interrupt enable.
- R5: A read at address 0 returns the over-temperature flag on bit 3 and the selection code on bits 2..0.
- R6: A write at address 1 loads the line request register. Data bit n sets the request for channel n.
- R7: A read at address 1 returns a channel group chosen by the code: 000 sequencer pending bits, 001 open-loop bits, 010 overload bits, 011 drive register, 110 request register, 111 thermal permit bits. The reserved codes 100 and 101 read as 0000.
- R8: Drive register bit n copies request bit n only in a cycle where accept bit n is high. Otherwise it holds.
- R9: The interrupt output is low exactly when the enable is set and at least one overload bit is high. It is not latched, so it returns high as soon as the overload bits clear.
- R10: A write strobe given while chip select is high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe; tie high for a non-multiplexed bus |
| a0 | input | 1 | Address bit |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| d_in | input | 4 | Data bus, inbound |
| d_out | output | 4 | Data bus, outbound |
| d_oe | output | 1 | Drive enable for d_out |
| st_pend | input | 4 | Sequencer pending bit per channel |
| st_open | input | 4 | Open-loop bit per channel |
| st_ovl | input | 4 | Overload bit per channel |
| st_therm | input | 4 | Thermal permit bit per channel |
| hot | input | 1 | Over-temperature flag |
| accept | input | 4 | Per-channel request acceptance pulse |
| line_req | output | 4 | Line request register |
| line_drv | output | 4 | Drive control register |
| int_n | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach is a write on a multiplexed bus. Here the latched address must differ from the live address pin when the strobe ends. The stimulus latches address 1 with the latch strobe high, then drops the strobe. It then drives the address pin to 0 and performs a write. The data must land in the request register, not the selection register. Drive-register updates are reached by loading requests first and then pulsing single accept bits. This shows that each channel copies alone.

// File: rtl/upport4.sv
module upport4 #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           a0,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [NCH-1:0] d_in,
  output logic [NCH-1:0] d_out,
  output logic           d_oe,
  input  logic [NCH-1:0] st_pend,
  input  logic [NCH-1:0] st_open,
  input  logic [NCH-1:0] st_ovl,
  input  logic [NCH-1:0] st_therm,
  input  logic           hot,
  input  logic [NCH-1:0] accept,
  output logic [NCH-1:0] line_req,
  output logic [NCH-1:0] line_drv,
  output logic           int_n
);
  localparam int SW = NCH + 5;

  logic [SW-1:0] s1, s2;
  logic          ale_s, a0_s, cs_s, rd_s, wr_s;
  logic [NCH-1:0] d_s;
  logic          addr_q, addr_eff;
  logic          wr_act, wr_act_q, wr_end;
  logic [NCH-1:0] wr_d;
  logic          wr_a;
  logic [2:0]    sel;
  logic          ie;
  logic [NCH-1:0] grp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, {NCH{1'b0}}};
      s2 <= {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, {NCH{1'b0}}};
    end else begin
      s1 <= {ale, a0, cs_n, rd_n, wr_n, d_in};
      s2 <= s1;
    end

  assign {ale_s, a0_s, cs_s, rd_s, wr_s, d_s} = s2;
  assign addr_eff = ale_s ? a0_s : addr_q;
  assign wr_act   = !cs_s && !wr_s;
  assign wr_end   = wr_act_q && !wr_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q   <= 1'b0;
      wr_act_q <= 1'b0;
      wr_d     <= '0;
      wr_a     <= 1'b0;
      sel      <= 3'b000;
      ie       <= 1'b0;
      line_req <= '0;
    end else begin
      addr_q   <= addr_eff;
      wr_act_q <= wr_act;
      if (wr_act) begin
        wr_d <= d_s;
        wr_a <= addr_eff;
      end
      if (wr_end) begin
        if (wr_a) line_req <= wr_d;
        else begin
          sel <= wr_d[2:0];
          ie  <= wr_d[3];
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) line_drv <= '0;
    else
      for (int i = 0; i < NCH; i++)
        if (accept[i]) line_drv[i] <= line_req[i];

  always_comb
    case (sel)
      3'b000:  grp = st_pend;
      3'b001:  grp = st_open;
      3'b010:  grp = st_ovl;
      3'b011:  grp = line_drv;
      3'b110:  grp = line_req;
      3'b111:  grp = st_therm;
      default: grp = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d_out <= '0;
      d_oe  <= 1'b0;
    end else begin
      d_oe  <= !cs_s && !rd_s;
      d_out <= addr_eff ? grp : {hot, sel};
    end

  assign int_n = !(ie && (|st_ovl));

  // R8: drive bits move only under accept
  a_r8_drv_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (line_drv != $past(line_drv)) |-> (($past(accept) & (line_drv ^ $past(line_drv))) == (line_drv ^ $past(line_drv))));

  // R6, R10: request register changes only at end of a selected write
  a_r6_req_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req != $past(line_req)) |-> $past(wr_end));

  // R4: selection code changes only at end of a selected write
  a_r4_sel_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> $past(wr_end));

  // R7: reserved codes read as zero
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_eff && sel[2:1] == 2'b10) |=> (d_out == '0));

  // R9: interrupt never asserted with enable clear
  a_r9_int_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> int_n);

  // R2: no drive one cycle after chip select seen high
  a_r2_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !d_oe);
endmodule

// File: tb/upport4_bench.sv
module upport4_bench;
  logic clk = 0, rst_n = 0;
  logic ale = 1, a0 = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [3:0] d_in = 0, d_out;
  logic d_oe;
  logic [3:0] st_pend = 4'h1, st_open = 4'h2, st_ovl = 4'h0, st_therm = 4'h8;
  logic hot = 0;
  logic [3:0] accept = 0, line_req, line_drv;
  logic int_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  upport4 u_upport4 (.clk, .rst_n, .ale, .a0, .cs_n, .rd_n, .wr_n, .d_in, .d_out, .d_oe,
    .st_pend, .st_open, .st_ovl, .st_therm, .hot, .accept, .line_req, .line_drv, .int_n);

  task automatic chk(string r, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic a, logic [3:0] d);
    a0 = a; d_in = d; cs_n = 0; wr_n = 0; idle(4);
    wr_n = 1; idle(1); cs_n = 1; idle(4);
  endtask

  task automatic bus_rd(logic a, output logic [3:0] v, output logic oe);
    a0 = a; cs_n = 0; rd_n = 0; idle(5);
    v = d_out; oe = d_oe;
    rd_n = 1; cs_n = 1; idle(4);
  endtask

  task automatic t_reset();
    chk("R1 int_n", int_n, 1); chk("R1 line_req", line_req, 0);
    chk("R1 line_drv", line_drv, 0); chk("R1 d_oe", d_oe, 0);
  endtask

  task automatic t_select();
    logic [3:0] v; logic oe;
    bus_rd(0, v, oe);
    chk("R1 sel reset", v, 0);
    chk("R2 oe during read", oe, 1);
    chk("R2 oe after read", d_oe, 0);
    bus_wr(0, 4'b0101);
    hot = 1;
    bus_rd(0, v, oe);
    chk("R4/R5 sel with hot", v, 4'b1101);
    hot = 0;
  endtask

  task automatic t_groups();
    logic [3:0] v; logic oe;
    bus_wr(1, 4'b0110);
    chk("R6 line_req", line_req, 4'b0110);
    bus_wr(0, 4'b0000); bus_rd(1, v, oe); chk("R7 code000", v, 4'h1);
    bus_wr(0, 4'b0001); bus_rd(1, v, oe); chk("R7 code001", v, 4'h2);
    st_ovl = 4'h3;
    bus_wr(0, 4'b0010); bus_rd(1, v, oe); chk("R7 code010", v, 4'h3);
    st_ovl = 4'h0;
    bus_wr(0, 4'b0011); bus_rd(1, v, oe); chk("R7 code011", v, 4'h0);
    bus_wr(0, 4'b0110); bus_rd(1, v, oe); chk("R7 code110", v, 4'b0110);
    bus_wr(0, 4'b0111); bus_rd(1, v, oe); chk("R7 code111", v, 4'h8);
    bus_wr(0, 4'b0100); bus_rd(1, v, oe); chk("R7 code100 reserved", v, 0);
    bus_wr(0, 4'b0101); bus_rd(1, v, oe); chk("R7 code101 reserved", v, 0);
  endtask

  task automatic t_accept();
    logic [3:0] v; logic oe;
    bus_wr(1, 4'b0101);
    idle(3); chk("R8 no accept", line_drv, 0);
    accept = 4'b0001; idle(1); accept = 0; idle(1);
    chk("R8 single accept", line_drv, 4'b0001);
    accept = 4'b1111; idle(1); accept = 0; idle(1);
    chk("R8 all accept", line_drv, 4'b0101);
    bus_wr(0, 4'b0011); bus_rd(1, v, oe);
    chk("R7 code011 drive", v, 4'b0101);
  endtask

  task automatic t_irq();
    bus_wr(0, 4'b1000);
    st_ovl = 0; #1 chk("R9 no ovl", int_n, 1);
    st_ovl = 4'b0100; #1 chk("R9 ovl enabled", int_n, 0);
    st_ovl = 0; #1 chk("R9 not latched", int_n, 1);
    bus_wr(0, 4'b0000);
    st_ovl = 4'b0100; #1 chk("R9 disabled", int_n, 1);
    st_ovl = 0;
  endtask

  task automatic t_deselect();
    logic [3:0] v; logic oe;
    bus_wr(1, 4'b0011);
    a0 = 1; d_in = 4'b1100; cs_n = 1; wr_n = 0; idle(5); wr_n = 1; idle(4);
    chk("R10 write ignored", line_req, 4'b0011);
    cs_n = 1; rd_n = 0; idle(5);
    chk("R2 no drive deselected", d_oe, 0);
    rd_n = 1; idle(2);
  endtask

  task automatic t_latch();
    ale = 1; a0 = 1; idle(4);
    ale = 0; idle(2); a0 = 0; idle(3);
    bus_wr(0, 4'b1010);
    chk("R3 latched addr write", line_req, 4'b1010);
    ale = 1; idle(4);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset(); t_select(); t_groups(); t_accept(); t_irq(); t_deselect(); t_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule